// File: doc/BRIEF.md
# I2C Master Byte Sequencer

This block decides which byte-level step an I2C master takes next. It does no bit timing. It sends single-cycle commands to a separate bit engine: generate a start, shift out a byte, shift in a byte while returning ACK or NACK, or generate a stop. After each command it waits for the engine's completion pulse. On a shifted-out byte, the pulse also carries the acknowledge the engine saw from the slave.

A transfer begins when software writes the enable bit while the sequencer is idle. Optional broadcast bytes are sent first, straight from their own holding register rather than from the transmit queue. After each acknowledged broadcast byte, the sequencer holds. It continues either with another broadcast byte or with an address write. With no broadcast pending, the first byte after start is taken from the transmit register if that register holds valid data. Otherwise the address register supplies it.

Bit 0 of that address byte selects the direction. A read collects a programmed number of bytes and presents each one on a receive output. A write keeps draining the transmit register until it runs dry. Any byte the slave refuses ends the transfer with a stop.

Top module: `i2c_xfer_seq`

## Requirements
- R1: After reset `busy`, `nackFlag`, `rxValid` and `cmdValid` are 0 and `rxData` is 0x00.
- R2: A cycle with `enWrite`=1 and `enData`=1 while idle makes the sequencer issue a START command in the next cycle, with `busy` high from that cycle. `busy` stays high until the engine reports the STOP complete, and is low afterwards.
- R3: An enable write that arrives while `busy` is high is ignored. No second transfer starts after the current one ends.
- R4: If `bcValid` is high when the start completes, the first byte sent is `bcData`, with `bcTake` pulsed. The transmit register is not consumed by that step.
- R5: After an acknowledged broadcast byte, no command is issued until `bcValid` or `addrWrite` is seen. `bcValid` sends another broadcast byte. `addrWrite` sends `addrData` as the address byte.
- R6: With no broadcast pending after start, the address byte is `txData` (with `txTake` pulsed) when `txValid` is high, and `addrData` otherwise.
- R7: When bit 0 of the address byte is 1, the sequencer issues `rdCount`+1 RECEIVE commands. `cmdNack`=1 is set on the last one only, and a STOP follows. `rdCount` is sampled when the address byte is issued, so 0 means one byte and 7 means eight.
- R8: Each received byte appears on `rxData` with a one-cycle `rxValid` pulse in the cycle after the edge that samples `engDone`.
- R9: When bit 0 of the address byte is 0, each acknowledged byte is followed by a SEND of `txData` (with `txTake`) while `txValid` is high. When `txValid` is low, a STOP is issued instead.
- R10: A SEND that completes with `engAck`=0 is followed by a STOP in the next cycle and sets `nackFlag`. The flag holds until the next START clears it.
- R11: Commands are single-cycle `cmdValid` pulses, encoded on `cmd` as 0 START, 1 SEND, 2 RECEIVE, 3 STOP. No new command is issued before the engine's `engDone` for the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enWrite | input | 1 | Strobe: enable bit written this cycle |
| enData | input | 1 | Value written to the enable bit |
| addrData | input | 8 | Address register contents |
| addrWrite | input | 1 | Strobe: address register written this cycle |
| txData | input | 8 | Transmit data register contents |
| txValid | input | 1 | Transmit register holds unsent data |
| txTake | output | 1 | Transmit register consumed this cycle |
| bcData | input | 8 | Broadcast byte register contents |
| bcValid | input | 1 | Broadcast register holds an unsent byte |
| bcTake | output | 1 | Broadcast register consumed this cycle |
| rdCount | input | 3 | Read length minus one |
| cmdValid | output | 1 | Command to the bit engine is valid |
| cmd | output | 2 | Command code: 0 START, 1 SEND, 2 RECEIVE, 3 STOP |
| cmdByte | output | 8 | Byte to shift out with SEND |
| cmdNack | output | 1 | RECEIVE answers with NACK instead of ACK |
| engDone | input | 1 | Bit engine finished the last command |
| engAck | input | 1 | Slave acknowledged the byte just sent |
| engRxByte | input | 8 | Byte shifted in by the last RECEIVE |
| busy | output | 1 | Transfer in progress |
| rxData | output | 8 | Last received byte |
| rxValid | output | 1 | Pulse: new byte on rxData |
| nackFlag | output | 1 | A sent byte was not acknowledged |

## Verification
The hardest state to reach is the broadcast hold. The sequencer stops there between an acknowledged broadcast byte and the address write, and it can be left in two different ways.

The bench's engine model answers each command after a fixed latency. It releases `addrWrite` only after the broadcast queue is empty and the engine has been quiet for several cycles. Any command issued too early therefore shows up as a reordered command log.

NACKs are placed on every byte position of a two-broadcast, two-data transfer. `rdCount` is altered after the first RECEIVE to show that the length was latched at address time.

// File: rtl/i2c_xfer_seq_pkg.sv
package i2c_xfer_seq_pkg;

  typedef enum logic [1:0] {
    CMD_START = 2'd0,
    CMD_SEND  = 2'd1,
    CMD_RECV  = 2'd2,
    CMD_STOP  = 2'd3
  } cmdKind_e;

  typedef enum logic [1:0] {
    SRC_ADDR = 2'd0,
    SRC_TX   = 2'd1,
    SRC_BC   = 2'd2
  } byteSrc_e;

  typedef enum logic [1:0] {
    PH_BC   = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } phase_e;

  // strobes from the control FSM into the datapath
  typedef struct packed {
    byteSrc_e srcSel;
    logic     ldHdr;
    logic     decCnt;
    logic     capRx;
    logic     setNack;
    logic     clrNack;
  } dpCtl_t;

endpackage

// File: rtl/i2c_xfer_seq_dp.sv
module i2c_xfer_seq_dp
  import i2c_xfer_seq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [DATA_W-1:0] txData,
  input  logic [DATA_W-1:0] addrData,
  input  logic [DATA_W-1:0] bcData,
  input  logic [DATA_W-1:0] engRxByte,
  input  logic [CNT_W-1:0]  rdCount,
  output logic [DATA_W-1:0] cmdByte,
  output logic [DATA_W-1:0] rxData,
  output logic              dirRead,
  output logic              lastByte,
  output logic              rxValid,
  output logic              nackFlag
);

  localparam logic [CNT_W-1:0] CNT_ZERO = '0;
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [CNT_W-1:0] remain;

  always_comb begin
    case (ctl.srcSel)
      SRC_TX:  cmdByte = txData;
      SRC_BC:  cmdByte = bcData;
      default: cmdByte = addrData;
    endcase
  end

  assign lastByte = (remain == CNT_ZERO);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remain   <= CNT_ZERO;
      dirRead  <= 1'b0;
      rxData   <= '0;
      rxValid  <= 1'b0;
      nackFlag <= 1'b0;
    end else begin
      if (ctl.ldHdr) begin
        dirRead <= cmdByte[0];
        remain  <= rdCount;
      end else if (ctl.decCnt) begin
        remain <= remain - CNT_ONE;
      end
      rxValid <= ctl.capRx;
      if (ctl.capRx) rxData <= engRxByte;
      if (ctl.clrNack)      nackFlag <= 1'b0;
      else if (ctl.setNack) nackFlag <= 1'b1;
    end
  end

  AST_CNT_FLOOR: assert property (@(posedge clk) disable iff (!rstN)
    ctl.decCnt |-> (remain != CNT_ZERO));  // R7
  AST_RX_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);  // R8

endmodule

// File: rtl/i2c_xfer_seq_ctrl.sv
module i2c_xfer_seq_ctrl
  import i2c_xfer_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     enWrite,
  input  logic     enData,
  input  logic     txValid,
  input  logic     bcValid,
  input  logic     addrWrite,
  input  logic     engDone,
  input  logic     engAck,
  input  logic     dirRead,
  input  logic     lastByte,
  output dpCtl_t   ctl,
  output logic     cmdValid,
  output cmdKind_e cmdKind,
  output logic     cmdNack,
  output logic     txTake,
  output logic     bcTake,
  output logic     busy
);

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_STARTW, S_HEAD, S_BCHOLD, S_SENDW,
    S_DATA, S_RECV, S_RECVW, S_STOP, S_STOPW
  } state_e;

  state_e state, stateNxt;
  phase_e phase, phaseNxt;

  always_comb begin
    stateNxt   = state;
    phaseNxt   = phase;
    ctl        = '0;
    ctl.srcSel = SRC_ADDR;
    cmdValid   = 1'b0;
    cmdKind    = CMD_START;
    cmdNack    = 1'b0;
    txTake     = 1'b0;
    bcTake     = 1'b0;
    case (state)
      S_IDLE: if (enWrite && enData) stateNxt = S_START;
      S_START: begin
        cmdValid    = 1'b1;
        cmdKind     = CMD_START;
        ctl.clrNack = 1'b1;
        stateNxt    = S_STARTW;
      end
      S_STARTW: if (engDone) stateNxt = S_HEAD;
      S_HEAD: begin
        cmdValid = 1'b1;
        cmdKind  = CMD_SEND;
        stateNxt = S_SENDW;
        if (bcValid) begin
          bcTake     = 1'b1;
          ctl.srcSel = SRC_BC;
          phaseNxt   = PH_BC;
        end else if (txValid) begin
          txTake     = 1'b1;
          ctl.srcSel = SRC_TX;
          ctl.ldHdr  = 1'b1;
          phaseNxt   = PH_ADDR;
        end else begin
          ctl.ldHdr  = 1'b1;
          phaseNxt   = PH_ADDR;
        end
      end
      S_BCHOLD: begin
        if (bcValid) begin
          cmdValid   = 1'b1;
          cmdKind    = CMD_SEND;
          bcTake     = 1'b1;
          ctl.srcSel = SRC_BC;
          phaseNxt   = PH_BC;
          stateNxt   = S_SENDW;
        end else if (addrWrite) begin
          cmdValid   = 1'b1;
          cmdKind    = CMD_SEND;
          ctl.ldHdr  = 1'b1;
          phaseNxt   = PH_ADDR;
          stateNxt   = S_SENDW;
        end
      end
      S_SENDW: begin
        if (engDone) begin
          if (!engAck) begin
            ctl.setNack = 1'b1;
            stateNxt    = S_STOP;
          end else begin
            case (phase)
              PH_BC:   stateNxt = S_BCHOLD;
              PH_ADDR: stateNxt = dirRead ? S_RECV : S_DATA;
              default: stateNxt = S_DATA;
            endcase
          end
        end
      end
      S_DATA: begin
        if (txValid) begin
          cmdValid   = 1'b1;
          cmdKind    = CMD_SEND;
          txTake     = 1'b1;
          ctl.srcSel = SRC_TX;
          phaseNxt   = PH_DATA;
          stateNxt   = S_SENDW;
        end else begin
          stateNxt = S_STOP;
        end
      end
      S_RECV: begin
        cmdValid = 1'b1;
        cmdKind  = CMD_RECV;
        cmdNack  = lastByte;
        stateNxt = S_RECVW;
      end
      S_RECVW: begin
        if (engDone) begin
          ctl.capRx = 1'b1;
          if (lastByte) stateNxt = S_STOP;
          else begin
            ctl.decCnt = 1'b1;
            stateNxt   = S_RECV;
          end
        end
      end
      S_STOP: begin
        cmdValid = 1'b1;
        cmdKind  = CMD_STOP;
        stateNxt = S_STOPW;
      end
      S_STOPW: if (engDone) stateNxt = S_IDLE;
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      phase <= PH_BC;
    end else begin
      state <= stateNxt;
      phase <= phaseNxt;
    end
  end

  assign busy = (state != S_IDLE);

  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (cmdValid && cmdKind == CMD_START));  // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !(cmdValid || txTake || bcTake));  // R3
  AST_TAKE_SEND: assert property (@(posedge clk) disable iff (!rstN)
    (txTake || bcTake) |-> (cmdValid && cmdKind == CMD_SEND));  // R4
  AST_NACK_STOP: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_SENDW && engDone && !engAck) |=> (cmdValid && cmdKind == CMD_STOP));  // R10
  AST_CMD_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid);  // R11

endmodule

// File: rtl/i2c_xfer_seq.sv
module i2c_xfer_seq
  import i2c_xfer_seq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enWrite,
  input  logic              enData,
  input  logic [DATA_W-1:0] addrData,
  input  logic              addrWrite,
  input  logic [DATA_W-1:0] txData,
  input  logic              txValid,
  output logic              txTake,
  input  logic [DATA_W-1:0] bcData,
  input  logic              bcValid,
  output logic              bcTake,
  input  logic [CNT_W-1:0]  rdCount,
  output logic              cmdValid,
  output logic [1:0]        cmd,
  output logic [DATA_W-1:0] cmdByte,
  output logic              cmdNack,
  input  logic              engDone,
  input  logic              engAck,
  input  logic [DATA_W-1:0] engRxByte,
  output logic              busy,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  output logic              nackFlag
);

  dpCtl_t   ctl;
  cmdKind_e cmdK;
  logic     dirRead;
  logic     lastByte;

  assign cmd = cmdK;

  i2c_xfer_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .enWrite(enWrite), .enData(enData),
    .txValid(txValid), .bcValid(bcValid), .addrWrite(addrWrite),
    .engDone(engDone), .engAck(engAck), .dirRead(dirRead), .lastByte(lastByte),
    .ctl(ctl), .cmdValid(cmdValid), .cmdKind(cmdK), .cmdNack(cmdNack),
    .txTake(txTake), .bcTake(bcTake), .busy(busy)
  );

  i2c_xfer_seq_dp #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .txData(txData), .addrData(addrData),
    .bcData(bcData), .engRxByte(engRxByte), .rdCount(rdCount),
    .cmdByte(cmdByte), .rxData(rxData), .dirRead(dirRead), .lastByte(lastByte),
    .rxValid(rxValid), .nackFlag(nackFlag)
  );

endmodule

// File: tb/tb_i2c_xfer_seq.sv
module tb_i2c_xfer_seq;

  localparam logic [1:0] K_START = 2'd0;
  localparam logic [1:0] K_SEND  = 2'd1;
  localparam logic [1:0] K_RECV  = 2'd2;
  localparam logic [1:0] K_STOP  = 2'd3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rstN, enWrite, enData, addrWrite, txValid, bcValid, engDone, engAck;
  logic [7:0] addrData, txData, bcData, engRxByte;
  logic [2:0] rdCount;
  logic       txTake, bcTake, cmdValid, cmdNack, busy, rxValid, nackFlag;
  logic [1:0] cmd;
  logic [7:0] cmdByte, rxData;

  i2c_xfer_seq dut (
    .clk(clk), .rstN(rstN), .enWrite(enWrite), .enData(enData),
    .addrData(addrData), .addrWrite(addrWrite), .txData(txData), .txValid(txValid),
    .txTake(txTake), .bcData(bcData), .bcValid(bcValid), .bcTake(bcTake),
    .rdCount(rdCount), .cmdValid(cmdValid), .cmd(cmd), .cmdByte(cmdByte),
    .cmdNack(cmdNack), .engDone(engDone), .engAck(engAck), .engRxByte(engRxByte),
    .busy(busy), .rxData(rxData), .rxValid(rxValid), .nackFlag(nackFlag)
  );

  int nTests = 0;
  int nFail  = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // engine model and stimulus queues
  logic [1:0] logKind [0:63];
  logic [7:0] logByte [0:63];
  logic       logNack [0:63];
  int         nLog;
  logic [7:0] rxLog [0:15];
  int         nRxLog;
  logic [7:0] txQ [0:15];
  int         txLen, txPtr;
  logic [7:0] bcQ [0:3];
  int         bcLen, bcPtr;
  int         nackAt, sendIdx, rxIdx, engCnt, gap;
  logic [1:0] pendKind;
  logic       needAddrW, flipRd;

  logic       cCmd = 0, cTx = 0, cBc = 0, cRxV = 0, cNack = 0;
  logic [1:0] cKind = 0;
  logic [7:0] cByte = 0, cRx = 0;

  always @(posedge clk) begin
    cCmd  <= cmdValid;
    cKind <= cmd;
    cByte <= cmdByte;
    cNack <= cmdNack;
    cTx   <= txTake;
    cBc   <= bcTake;
    cRxV  <= rxValid;
    cRx   <= rxData;
  end

  initial begin
    addrWrite = 0; txValid = 0; bcValid = 0; engDone = 0; engAck = 0;
    addrData = 0; txData = 0; bcData = 0; engRxByte = 0; rdCount = 0;
    nLog = 0; nRxLog = 0; txLen = 0; txPtr = 0; bcLen = 0; bcPtr = 0;
    nackAt = 99; sendIdx = 0; rxIdx = 0; engCnt = 0; gap = 0;
    pendKind = 0; needAddrW = 0; flipRd = 0;
    forever begin
      @(negedge clk);
      engDone   = 0;
      addrWrite = 0;
      if (cTx) txPtr++;
      if (cBc) bcPtr++;
      if (cRxV) begin
        if (nRxLog < 16) rxLog[nRxLog] = cRx;
        nRxLog++;
      end
      if (engCnt > 0) begin
        engCnt--;
        if (engCnt == 0) begin
          engDone = 1;
          engAck  = 1;
          if (pendKind == K_SEND) begin
            engAck = (sendIdx != nackAt);
            sendIdx++;
          end
          if (pendKind == K_RECV) begin
            engRxByte = 8'h5A ^ 8'(rxIdx * 8'h13);
            rxIdx++;
          end
        end
      end
      if (cCmd) begin
        if (engCnt != 0 || engDone) chk(0, "R11 command before engine done", nLog, 0);
        if (nLog < 64) begin
          logKind[nLog] = cKind;
          logByte[nLog] = cByte;
          logNack[nLog] = cNack;
        end
        nLog++;
        engCnt   = 2;
        pendKind = cKind;
        if (cKind == K_RECV && flipRd) begin
          rdCount = rdCount ^ 3'b101;
          flipRd  = 0;
        end
      end
      txValid = (txPtr < txLen);
      txData  = (txPtr < txLen) ? txQ[txPtr] : 8'h00;
      bcValid = (bcPtr < bcLen);
      bcData  = (bcPtr < bcLen) ? bcQ[bcPtr] : 8'h00;
      if (needAddrW && busy && bcPtr == bcLen && engCnt == 0 && !engDone && !cCmd) gap++;
      else gap = 0;
      if (gap == 3) begin
        addrWrite = 1;
        needAddrW = 0;
        gap = 0;
      end
    end
  end

  logic [1:0] expKind [0:63];
  logic [7:0] expByte [0:63];
  logic       expNack [0:63];
  int         nExp;

  task automatic addExp(input logic [1:0] k, input logic [7:0] b, input logic n);
    expKind[nExp] = k;
    expByte[nExp] = b;
    expNack[nExp] = n;
    nExp++;
  endtask

  task automatic runXfer(input int nBc, input bit fromTx, input logic [7:0] addr,
                         input int nData, input int rc, input int nk, input bit poke);
    int k, txUsed, bcUsed, t, endLog;
    bit stopped, rdOk;
    logic [7:0] dat [0:7];
    @(negedge clk);
    bcLen = nBc; bcPtr = 0;
    for (int i = 0; i < nBc; i++) bcQ[i] = 8'hC0 + 8'(i * 5);
    txPtr = 0; txLen = 0;
    if (fromTx && nBc == 0) begin txQ[0] = addr; txLen = 1; end
    for (int j = 0; j < nData; j++) begin
      dat[j] = 8'h20 + 8'(j * 9 + nData);
      if (!addr[0]) begin txQ[txLen] = dat[j]; txLen++; end
    end
    addrData = addr; rdCount = 3'(rc); nackAt = nk;
    sendIdx = 0; rxIdx = 0; nLog = 0; nRxLog = 0;
    needAddrW = (nBc > 0); flipRd = 1;
    // expected command stream
    nExp = 0; k = 0; stopped = 0; txUsed = 0; bcUsed = 0; rdOk = 0;
    addExp(K_START, 8'h00, 0);
    for (int i = 0; i < nBc && !stopped; i++) begin
      addExp(K_SEND, bcQ[i], 0); bcUsed++;
      if (k == nk) stopped = 1;
      k++;
    end
    if (!stopped) begin
      addExp(K_SEND, addr, 0);
      if (fromTx && nBc == 0) txUsed++;
      if (k == nk) stopped = 1;
      k++;
      if (!stopped && addr[0]) begin
        for (int r = 0; r <= rc; r++) addExp(K_RECV, 8'h00, (r == rc));
        rdOk = 1;
      end else if (!stopped) begin
        for (int j = 0; j < nData && !stopped; j++) begin
          addExp(K_SEND, dat[j], 0); txUsed++;
          if (k == nk) stopped = 1;
          k++;
        end
      end
    end
    addExp(K_STOP, 8'h00, 0);
    @(negedge clk);
    @(negedge clk);
    enWrite = 1; enData = 1;
    @(negedge clk);
    enWrite = 0;
    chk(busy == 1'b1 && cmdValid == 1'b1 && cmd == K_START, "R2 start after enable",
        {busy, cmdValid, cmd}, 4'b1100);
    t = 0;
    while (busy && t < 3000) begin
      @(negedge clk);
      enWrite = (poke && t == 5);
      t++;
    end
    enWrite = 0;
    endLog = nLog;
    repeat (6) @(negedge clk);
    chk(busy == 1'b0, "R2 busy low after stop", busy, 0);
    chk(nLog == endLog, "R3 no restart from enable written while busy", nLog, endLog);
    chk(nLog == nExp, "R11 command count", nLog, nExp);
    for (int i = 0; i < nExp && i < nLog; i++) begin
      chk(logKind[i] == expKind[i], "R11 command code order", logKind[i], expKind[i]);
      if (expKind[i] == K_SEND)
        chk(logByte[i] == expByte[i],
            (nBc > 0 && i <= nBc) ? "R4 R5 broadcast/address byte" : "R6 R9 sent byte",
            logByte[i], expByte[i]);
      if (expKind[i] == K_RECV)
        chk(logNack[i] == expNack[i], "R7 nack only on last read byte", logNack[i], expNack[i]);
    end
    chk(nRxLog == (rdOk ? rc + 1 : 0), "R8 received byte count", nRxLog, rdOk ? rc + 1 : 0);
    for (int r = 0; r < nRxLog && r < 8 && rdOk; r++)
      chk(rxLog[r] == (8'h5A ^ 8'(r * 8'h13)), "R8 received byte value", rxLog[r],
          8'h5A ^ 8'(r * 8'h13));
    chk(nackFlag == stopped, "R10 nack flag", nackFlag, stopped);
    chk(txPtr == txUsed, "R6 R9 transmit entries consumed", txPtr, txUsed);
    chk(bcPtr == bcUsed, "R4 R5 broadcast entries consumed", bcPtr, bcUsed);
    needAddrW = 0;
    bcLen = 0; bcPtr = 0; txLen = 0; txPtr = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL R11 watchdog expired: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    rstN = 0; enWrite = 0; enData = 0;
    repeat (3) @(negedge clk);
    chk(busy == 0, "R1 busy at reset", busy, 0);
    chk(nackFlag == 0, "R1 nackFlag at reset", nackFlag, 0);
    chk(rxData == 8'h00, "R1 rxData at reset", rxData, 0);
    chk(rxValid == 0 && cmdValid == 0, "R1 no pulse at reset", {rxValid, cmdValid}, 0);
    rstN = 1;
    @(negedge clk);
    chk(busy == 0, "R1 idle after reset release", busy, 0);
    // reads: every count, address from both sources (R6 R7 R8)
    for (int rc = 0; rc < 8; rc++)
      runXfer(0, rc[0], {7'(8'h20 + rc), 1'b1}, 0, rc, 99, 0);
    // writes across broadcast and data lengths (R4 R5 R9), with busy enable pokes (R3)
    for (int nb = 0; nb < 3; nb++)
      for (int nd = 0; nd < 4; nd++)
        runXfer(nb, 1'b1, {7'(8'h30 + nb * 4 + nd), 1'b0}, nd, 0, 99, (nd == 2));
    // refusal at every byte position (R10)
    for (int nk = 0; nk < 5; nk++)
      runXfer(2, 1'b1, 8'h6C, 2, 0, nk, 0);
    // read after broadcast, and refused read address (R5 R7 R10)
    runXfer(1, 1'b0, 8'h4B, 0, 3, 99, 0);
    runXfer(0, 1'b0, 8'h4B, 0, 3, 0, 0);
    runXfer(0, 1'b0, 8'h4B, 0, 2, 99, 1);
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule